// File: doc/BRIEF.md
# Buffered PWM Register Synchronizer

This block sits between a bus and the core of a two-channel PWM timer. Software writes the next period (modulo), the next compare value of each channel and the next output-mask pattern into shadow buffers. None of these writes reaches the timer until a synchronization event occurs. At that event the buffered values are copied into the active registers in one clock edge. The same event can also send a one-cycle pulse that tells the timer counter to reload its initial value.

Two sources can raise a synchronization event: a one-cycle software strobe and a hardware trigger line, which acts on its rising edge. A trigger-mode bit sits in a bus-writable configuration word. With the bit clear, either source updates every target. With the bit set, the sources split the targets. The software strobe then updates only the value group (modulo and compares). A hardware edge then updates only the output group (output mask and counter reload). An enhanced-synchronization select input overrides the split: while it is high, the trigger-mode bit has no effect.

Top module: `pwm_reg_sync`

## Requirements
- R1: After a synchronous reset, the active modulo, both active compares, the output mask, every buffer and the trigger-mode bit read 0, and `cnt_init` is low.
- R2: Bus writes reach the buffers only. The address map is: 0 = modulo, 1 = channel 0 compare, 2 = channel 1 compare, 3 = output mask (bit i masks channel i), 4 = configuration (bit 0 = trigger-mode bit). With no qualifying trigger, the active outputs hold their values.
- R3: With the trigger-mode bit at 0, `sw_trig` high at a clock edge loads all buffers into the active registers. In the next cycle the new values are visible and `cnt_init` is high for that one cycle.
- R4: With the trigger-mode bit at 0, a rising edge on `hw_trig` has the same effect as R3. A level held high triggers only once.
- R5: With the trigger-mode bit at 1 and `enh_sel` at 0, `sw_trig` updates only the modulo and compares. The output mask holds and no `cnt_init` pulse is produced.
- R6: With the trigger-mode bit at 1 and `enh_sel` at 0, a rising edge on `hw_trig` updates only the output mask and produces a `cnt_init` pulse. The modulo and compares hold.
- R7: With `enh_sel` at 1, the trigger-mode bit is ignored and both sources behave as in R3 and R4.
- R8: When both sources qualify in the same cycle, each group is loaded once and `cnt_init` is a single one-cycle pulse.
- R9: A bus write in the same cycle as a trigger lands in the buffer. The active register takes the buffer value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W (3) | Buffer/config word address |
| wr_data | input | CNT_W (16) | Write data |
| sw_trig | input | 1 | One-cycle software synchronization strobe |
| hw_trig | input | 1 | Hardware trigger, rising-edge active |
| enh_sel | input | 1 | Enhanced synchronization select; 1 overrides the trigger-mode bit |
| mod_out | output | CNT_W | Active modulo value |
| cmp_out | output | NUM_CH*CNT_W | Active compares, channel i in bits [i*CNT_W +: CNT_W] |
| mask_out | output | NUM_CH | Active output mask |
| cnt_init | output | 1 | One-cycle counter reload pulse |

## Verification
The assertions assume that `hw_trig` is synchronous to `clk` and that its previous level after reset counts as low. They also assume that `sw_trig` is a strobe the bench may hold for only one sampled edge at a time. The bench drives every input at the falling edge, so each stimulus is stable across the sampling edge. It keeps `hw_trig` edges at least one cycle apart in the directed phases. The random phase may toggle any input on any cycle. The cycle-by-cycle model handles that, because it tracks the previous hardware level itself.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  // Qualified update requests for one clock edge
  typedef struct packed {
    logic upd_vals;  // modulo + compares
    logic upd_outs;  // output mask + counter reload
  } sync_req_t;

  function automatic int unsigned addr_mod();
    return 0;
  endfunction

  function automatic int unsigned addr_cmp(input int unsigned ch);
    return 1 + ch;
  endfunction

  function automatic int unsigned addr_mask(input int unsigned nch);
    return nch + 1;
  endfunction

  function automatic int unsigned addr_cfg(input int unsigned nch);
    return nch + 2;
  endfunction

endpackage

// File: rtl/pwm_sync_trig.sv
module pwm_sync_trig
  import pwm_sync_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sw_trig,
  input  logic      hw_trig,
  input  logic      split_mode,
  input  logic      enh_sel,
  output sync_req_t req
);

  logic hw_prev;
  logic hw_rise;
  logic split_active;

  always_ff @(posedge clk) begin
    if (rst) hw_prev <= 1'b0;
    else     hw_prev <= hw_trig;
  end

  assign hw_rise      = hw_trig & ~hw_prev;
  assign split_active = split_mode & ~enh_sel;

  always_comb begin
    if (split_active) begin
      req.upd_vals = sw_trig;
      req.upd_outs = hw_rise;
    end else begin
      req.upd_vals = sw_trig | hw_rise;
      req.upd_outs = sw_trig | hw_rise;
    end
  end

endmodule

// File: rtl/pwm_sync_bufbank.sv
module pwm_sync_bufbank
  import pwm_sync_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CNT_W-1:0]              wr_data,
  output logic [CNT_W-1:0]              buf_mod,
  output logic [NUM_CH-1:0][CNT_W-1:0]  buf_cmp,
  output logic [NUM_CH-1:0]             buf_mask,
  output logic                          cfg_split
);

  localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(addr_mod());
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(addr_mask(NUM_CH));
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(addr_cfg(NUM_CH));

  always_ff @(posedge clk) begin
    if (rst) buf_mod <= '0;
    else if (wr_en && wr_addr == A_MOD) buf_mod <= wr_data;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(addr_cmp(g));
    always_ff @(posedge clk) begin
      if (rst) buf_cmp[g] <= '0;
      else if (wr_en && wr_addr == A_CMP) buf_cmp[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) buf_mask <= '0;
    else if (wr_en && wr_addr == A_MASK) buf_mask <= wr_data[NUM_CH-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_split <= 1'b0;
    else if (wr_en && wr_addr == A_CFG) cfg_split <= wr_data[0];
  end

endmodule

// File: rtl/pwm_sync_active.sv
module pwm_sync_active
  import pwm_sync_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  sync_req_t                     req,
  input  logic [CNT_W-1:0]              buf_mod,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  buf_cmp,
  input  logic [NUM_CH-1:0]             buf_mask,
  output logic [CNT_W-1:0]              act_mod,
  output logic [NUM_CH-1:0][CNT_W-1:0]  act_cmp,
  output logic [NUM_CH-1:0]             act_mask,
  output logic                          init_pulse
);

  always_ff @(posedge clk) begin
    if (rst) act_mod <= '0;
    else if (req.upd_vals) act_mod <= buf_mod;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_act
    always_ff @(posedge clk) begin
      if (rst) act_cmp[g] <= '0;
      else if (req.upd_vals) act_cmp[g] <= buf_cmp[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mask   <= '0;
      init_pulse <= 1'b0;
    end else begin
      init_pulse <= req.upd_outs;
      if (req.upd_outs) act_mask <= buf_mask;
    end
  end

endmodule

// File: rtl/pwm_reg_sync.sv
module pwm_reg_sync
  import pwm_sync_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CNT_W-1:0]         wr_data,
  input  logic                     sw_trig,
  input  logic                     hw_trig,
  input  logic                     enh_sel,
  output logic [CNT_W-1:0]         mod_out,
  output logic [NUM_CH*CNT_W-1:0]  cmp_out,
  output logic [NUM_CH-1:0]        mask_out,
  output logic                     cnt_init
);

  sync_req_t                     req;
  logic [CNT_W-1:0]              buf_mod;
  logic [NUM_CH-1:0][CNT_W-1:0]  buf_cmp;
  logic [NUM_CH-1:0]             buf_mask;
  logic                          cfg_split;
  logic [NUM_CH-1:0][CNT_W-1:0]  act_cmp;

  pwm_sync_bufbank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .buf_mod(buf_mod), .buf_cmp(buf_cmp), .buf_mask(buf_mask), .cfg_split(cfg_split)
  );

  pwm_sync_trig u_trig (
    .clk(clk), .rst(rst), .sw_trig(sw_trig), .hw_trig(hw_trig),
    .split_mode(cfg_split), .enh_sel(enh_sel), .req(req)
  );

  pwm_sync_active #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_act (
    .clk(clk), .rst(rst), .req(req),
    .buf_mod(buf_mod), .buf_cmp(buf_cmp), .buf_mask(buf_mask),
    .act_mod(mod_out), .act_cmp(act_cmp), .act_mask(mask_out), .init_pulse(cnt_init)
  );

  assign cmp_out = act_cmp;

endmodule

// File: rtl/pwm_reg_sync_chk.sv
module pwm_reg_sync_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_trig,
  input logic              hw_trig,
  input logic              enh_sel,
  input logic              split_mode,
  input logic [CNT_W-1:0]  buf_mod,
  input logic [CNT_W-1:0]  mod_out,
  input logic [NUM_CH-1:0] mask_out,
  input logic              cnt_init
);

  logic hw_seen;
  logic rise;
  logic split_on;

  always_ff @(posedge clk) begin
    if (rst) hw_seen <= 1'b0;
    else     hw_seen <= hw_trig;
  end

  assign rise     = hw_trig && !hw_seen;
  assign split_on = split_mode && !enh_sel;

  AST_IDLE_HOLDS_MOD: assert property (@(posedge clk) disable iff (rst)
    (!sw_trig && !rise) |=> $stable(mod_out));  // R2

  AST_IDLE_NO_INIT: assert property (@(posedge clk) disable iff (rst)
    (!sw_trig && !rise) |=> !cnt_init);  // R2

  AST_SW_LOADS_MOD: assert property (@(posedge clk) disable iff (rst)
    (sw_trig && !split_on) |=> (mod_out == $past(buf_mod) && cnt_init));  // R3

  AST_SPLIT_SW_KEEPS_MASK: assert property (@(posedge clk) disable iff (rst)
    (split_on && !rise) |=> ($stable(mask_out) && !cnt_init));  // R5

  AST_SPLIT_HW_KEEPS_MOD: assert property (@(posedge clk) disable iff (rst)
    (split_on && !sw_trig) |=> $stable(mod_out));  // R6

  AST_ENH_HW_LOADS_MOD: assert property (@(posedge clk) disable iff (rst)
    (enh_sel && rise) |=> (mod_out == $past(buf_mod)));  // R7

endmodule

bind pwm_reg_sync pwm_reg_sync_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .sw_trig(sw_trig), .hw_trig(hw_trig), .enh_sel(enh_sel),
  .split_mode(cfg_split), .buf_mod(buf_mod), .mod_out(mod_out),
  .mask_out(mask_out), .cnt_init(cnt_init)
);

// File: tb/tb_pwm_reg_sync.sv
module tb_pwm_reg_sync;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;

  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic sw_trig = 0, hw_trig = 0, enh_sel = 0;
  logic [CNT_W-1:0]        mod_out;
  logic [NUM_CH*CNT_W-1:0] cmp_out;
  logic [NUM_CH-1:0]       mask_out;
  logic                    cnt_init;

  always #5 clk = ~clk;

  pwm_reg_sync #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sw_trig(sw_trig), .hw_trig(hw_trig), .enh_sel(enh_sel),
    .mod_out(mod_out), .cmp_out(cmp_out), .mask_out(mask_out), .cnt_init(cnt_init)
  );

  // behavioural reference
  int unsigned m_buf[NUM_CH+2];   // 0 mod, 1..NUM_CH cmp, NUM_CH+1 mask
  int unsigned m_act[NUM_CH+2];
  bit m_split, m_hw_prev, m_init;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_buf[i]) begin m_buf[i] = 0; m_act[i] = 0; end
      m_split = 0; m_hw_prev = 0; m_init = 0;
    end else begin
      bit rise, do_vals, do_outs;
      rise = hw_trig && !m_hw_prev;
      if (m_split && !enh_sel) begin
        do_vals = sw_trig; do_outs = rise;
      end else begin
        do_vals = sw_trig || rise; do_outs = do_vals;
      end
      if (do_vals) for (int i = 0; i <= NUM_CH; i++) m_act[i] = m_buf[i];
      if (do_outs) m_act[NUM_CH+1] = m_buf[NUM_CH+1];
      m_init = do_outs;
      m_hw_prev = hw_trig;
      if (wr_en) begin
        if (int'(wr_addr) <= NUM_CH) m_buf[wr_addr] = wr_data;
        else if (int'(wr_addr) == NUM_CH+1) m_buf[NUM_CH+1] = wr_data & ((1 << NUM_CH) - 1);
        else if (int'(wr_addr) == NUM_CH+2) m_split = wr_data[0];
      end
    end
  end

  task automatic chk(input string what, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("mod", mod_out, m_act[0]);
      for (int i = 0; i < NUM_CH; i++) chk("cmp", cmp_out[i*CNT_W +: CNT_W], m_act[1+i]);
      chk("mask", mask_out, m_act[NUM_CH+1]);
      chk("cnt_init", cnt_init, m_init);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    wr_en = 0; sw_trig = 0;
  endtask

  task automatic wr(input int a, input int unsigned d);
    @(negedge clk);
    wr_en = 1; wr_addr = ADDR_W'(a); wr_data = CNT_W'(d); sw_trig = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load_all(input int unsigned base);
    wr(0, base);
    for (int i = 0; i < NUM_CH; i++) wr(1 + i, base + 16'h11 * (i + 1));
    wr(NUM_CH + 1, base);
  endtask

  task automatic sw_pulse();
    @(negedge clk); sw_trig = 1;
    @(negedge clk); sw_trig = 0;
  endtask

  task automatic hw_edge(input int hold);
    @(negedge clk); hw_trig = 1;
    repeat (hold) @(negedge clk);
    hw_trig = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    cur_req = "R2";
    load_all(16'h1230);
    idle(3);
    cur_req = "R3";
    sw_pulse(); idle(2);
    cur_req = "R4";
    load_all(16'h0402);
    hw_edge(5); idle(2);
    cur_req = "R5";
    wr(NUM_CH + 2, 1);
    load_all(16'h5501);
    sw_pulse(); idle(2);
    cur_req = "R6";
    hw_edge(1); load_all(16'h6602); hw_edge(3); idle(2);
    cur_req = "R7";
    enh_sel = 1; load_all(16'h7703);
    hw_edge(1); load_all(16'h7780); sw_pulse();
    enh_sel = 0; idle(2);
    cur_req = "R8";
    wr(NUM_CH + 2, 0); load_all(16'h8801);
    @(negedge clk); sw_trig = 1; hw_trig = 1;
    @(negedge clk); sw_trig = 0; hw_trig = 0;
    idle(2);
    cur_req = "R9";
    @(negedge clk); sw_trig = 1; wr_en = 1; wr_addr = 0; wr_data = 16'h9999;
    @(negedge clk); sw_trig = 0; wr_en = 0;
    idle(2); sw_pulse(); idle(2);
    cur_req = "R8";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      wr_en = $urandom_range(0, 1) == 1;
      wr_addr = ADDR_W'($urandom_range(0, NUM_CH + 2));
      wr_data = CNT_W'($urandom);
      sw_trig = $urandom_range(0, 3) == 0;
      hw_trig = $urandom_range(0, 2) == 0;
      enh_sel = $urandom_range(0, 4) == 0;
    end
    @(negedge clk); wr_en = 0; sw_trig = 0; hw_trig = 0; enh_sel = 0;
    cur_req = "R1";
    rst = 1; idle(2); rst = 0; idle(2);
    finish_run();
  end
endmodule